// File: doc/BRIEF.md
# Two-Section Carry Select Adder

This block is a purely combinational binary adder. It takes two unsigned operands and a single carry input, and it returns their sum together with a carry output. It has no clock and no stored state, so its outputs follow its inputs after logic delay alone. It is meant to sit inside a datapath where the carry path is the critical path.

The operand is cut into equal 4-bit sections. Every section, the lowest one included, is built twice. Each copy is a ripple chain of full adders. One copy assumes a carry of 0 entering the section and the other assumes a carry of 1. A 2-to-1 multiplexer per section keeps the right result. The external carry steers the lowest section. Every higher section is steered by a carry made by AND/OR select logic from the conditional carries of the sections below it.

The final carry output does not pass through a chain of select stages. It is formed by one flattened AND-OR network over all the conditional section carries. The default width is 8 bits, which gives two sections. The same code builds 16-bit and 32-bit adders by changing a parameter.

Top module: `csaAdder`

## Requirements
- R1: For every input combination, the 9-bit value {carryOut, sumOut} of the 8-bit adder equals opA + opB + carryIn.
- R2: Bits [3:0] of sumOut equal (opA[3:0] + opB[3:0] + carryIn) mod 16. Within each section, the result that assumes carry 1 is exactly one more than the result that assumes carry 0, counting the section carry as the top bit.
- R3: Bits [7:4] of sumOut equal (opA[7:4] + opB[7:4] + c3) mod 16. Here c3 is 1 exactly when opA[3:0] + opB[3:0] + carryIn exceeds 15. A section whose carry is set under an assumed carry of 0 also has it set under an assumed carry of 1.
- R4: carryOut is 1 whenever the upper section alone overflows (opA[7:4] + opB[7:4] > 15), whatever carryIn is. The flattened carry-out network agrees with a carry chained section by section.
- R5: When opA = 0xFF and opB = 0x00, a carryIn of 1 gives sumOut = 0x00 and carryOut = 1. A carryIn of 0 gives sumOut = 0xFF and carryOut = 0.
- R6: Built with DATA_W = 16 and DATA_W = 32 (4-bit sections), {carryOut, sumOut} equals opA + opB + carryIn.
- R7: The outputs depend only on the present inputs. Applying a vector again after other vectors gives the same result as before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | DATA_W | First unsigned operand |
| opB | input | DATA_W | Second unsigned operand |
| carryIn | input | 1 | Carry into the lowest section |
| sumOut | output | DATA_W | Sum bits |
| carryOut | output | 1 | Carry out of the top section |

## Verification
Two select actions can change in the same evaluation. One is the lowest-section multiplexer switching on carryIn. The other is the upper-section multiplexer switching on c3. When the lower section is all-propagate, a flip of carryIn also flips c3, so both selects and the flattened carry-out move together. The bench provokes this with directed vectors such as 0x0F + 0x00 and 0xFF + 0x00 under both carry values, and the exhaustive sweep covers it as well. Each case is judged by comparing the sum bits and carryOut against a behavioural integer sum, and by checking both section fields separately.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // Width of one ripple section
  localparam int CSA_SECT_W = 4;

  // Number of sections needed for a given width
  function automatic int csaSectCount(input int dataW, input int sectW);
    return dataW / sectW;
  endfunction
endpackage

// File: rtl/csaSectionAdder.sv
module csaSectionAdder #(
  parameter int SECT_W = 4
) (
  input  logic [SECT_W-1:0] opA,
  input  logic [SECT_W-1:0] opB,
  input  logic              carryIn,
  output logic [SECT_W-1:0] sumOut,
  output logic              carryOut
);
  logic [SECT_W:0] ripple;

  assign ripple[0] = carryIn;

  for (genvar g = 0; g < SECT_W; g++) begin : g_bit
    assign sumOut[g]   = opA[g] ^ opB[g] ^ ripple[g];
    assign ripple[g+1] = (opA[g] & opB[g]) | (opA[g] & ripple[g]) | (opB[g] & ripple[g]);
  end

  assign carryOut = ripple[SECT_W];
endmodule

// File: rtl/csaDatapath.sv
module csaDatapath #(
  parameter int DATA_W = 8,
  parameter int SECT_W = 4
) (
  input  logic [DATA_W-1:0]                 opA,
  input  logic [DATA_W-1:0]                 opB,
  input  logic [csa_pkg::csaSectCount(DATA_W, SECT_W)-1:0] sectSel,
  output logic [csa_pkg::csaSectCount(DATA_W, SECT_W)-1:0] condCarry0,
  output logic [csa_pkg::csaSectCount(DATA_W, SECT_W)-1:0] condCarry1,
  output logic [DATA_W-1:0]                 sumOut
);
  localparam int NUM_SECT = csa_pkg::csaSectCount(DATA_W, SECT_W);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic [SECT_W-1:0] condSum0;
    logic [SECT_W-1:0] condSum1;

    csaSectionAdder #(.SECT_W(SECT_W)) u_add0 (
      .opA(opA[s*SECT_W +: SECT_W]),
      .opB(opB[s*SECT_W +: SECT_W]),
      .carryIn(1'b0),
      .sumOut(condSum0),
      .carryOut(condCarry0[s])
    );

    csaSectionAdder #(.SECT_W(SECT_W)) u_add1 (
      .opA(opA[s*SECT_W +: SECT_W]),
      .opB(opB[s*SECT_W +: SECT_W]),
      .carryIn(1'b1),
      .sumOut(condSum1),
      .carryOut(condCarry1[s])
    );

    assign sumOut[s*SECT_W +: SECT_W] = sectSel[s] ? condSum1 : condSum0;

    always_comb begin
      // R2
      cond_pair_chk: assert ({condCarry1[s], condSum1} ==
                             (SECT_W+1)'({condCarry0[s], condSum0} + (SECT_W+1)'(1)))
        else $error("conditional section results disagree in section %0d", s);
    end
  end
endmodule

// File: rtl/csaSelectCtl.sv
module csaSelectCtl #(
  parameter int NUM_SECT = 2
) (
  input  logic                carryIn,
  input  logic [NUM_SECT-1:0] condCarry0,
  input  logic [NUM_SECT-1:0] condCarry1,
  output logic [NUM_SECT-1:0] sectSel,
  output logic                carryOut
);
  // Carry entering each section, chained stage by stage
  logic [NUM_SECT:0] chainCarry;
  // Product of carry-when-1 terms from a section up to the top
  logic [NUM_SECT:0] tailProd;
  logic [NUM_SECT-1:0] genTerm;
  logic cinTerm;

  assign chainCarry[0]      = carryIn;
  assign tailProd[NUM_SECT] = 1'b1;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_chain
    assign chainCarry[i+1] = (chainCarry[i] & condCarry1[i]) | condCarry0[i];
    assign sectSel[i]      = chainCarry[i];
  end

  for (genvar j = 0; j < NUM_SECT; j++) begin : g_flat
    assign tailProd[j] = tailProd[j+1] & condCarry1[j];
    assign genTerm[j]  = condCarry0[j] & tailProd[j+1];
  end

  assign cinTerm  = carryIn & tailProd[0];
  assign carryOut = cinTerm | (|genTerm);

  always_comb begin
    // R4
    carry_match_chk: assert (carryOut == chainCarry[NUM_SECT])
      else $error("flattened carry-out differs from chained carry");
    // R3
    cond_order_chk: assert ((condCarry0 & ~condCarry1) == '0)
      else $error("carry set under carry 0 but clear under carry 1");
  end
endmodule

// File: rtl/csaAdder.sv
module csaAdder #(
  parameter int DATA_W = 8,
  parameter int SECT_W = csa_pkg::CSA_SECT_W
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut
);
  localparam int NUM_SECT = csa_pkg::csaSectCount(DATA_W, SECT_W);

  logic [NUM_SECT-1:0] sectSel;
  logic [NUM_SECT-1:0] condCarry0;
  logic [NUM_SECT-1:0] condCarry1;

  initial begin
    // R6
    width_split_chk: assert (DATA_W % SECT_W == 0)
      else $error("DATA_W must be a multiple of SECT_W");
  end

  csaSelectCtl #(.NUM_SECT(NUM_SECT)) u_ctl (
    .carryIn(carryIn),
    .condCarry0(condCarry0),
    .condCarry1(condCarry1),
    .sectSel(sectSel),
    .carryOut(carryOut)
  );

  csaDatapath #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_dp (
    .opA(opA),
    .opB(opB),
    .sectSel(sectSel),
    .condCarry0(condCarry0),
    .condCarry1(condCarry1),
    .sumOut(sumOut)
  );

  always_comb begin
    // R1
    value_identity_chk: assert ({carryOut, sumOut} ==
                                (DATA_W+1)'({1'b0, opA} + {1'b0, opB} + (DATA_W+1)'(carryIn)))
      else $error("sum value mismatch");
  end
endmodule

// File: tb/csaAdder_tb.sv
module csaAdder_tb;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic        c32 = 1'b0, co32;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  csaAdder #(.DATA_W(8)) u_dut (
    .opA(a8), .opB(b8), .carryIn(c8), .sumOut(s8), .carryOut(co8));
  csaAdder #(.DATA_W(16)) u_dut16 (
    .opA(a16), .opB(b16), .carryIn(c16), .sumOut(s16), .carryOut(co16));
  csaAdder #(.DATA_W(32)) u_dut32 (
    .opA(a32), .opB(b32), .carryIn(c32), .sumOut(s32), .carryOut(co32));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT && !done) begin
      done = 1;
      errors = errors + 1;
      $display("FAIL watchdog expired got=%0d cycles exp<=%0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive on posedge, compare at negedge
  task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic c);
    @(posedge clk);
    a8 <= a; b8 <= b; c8 <= c;
    a16 <= 16'($urandom); b16 <= 16'($urandom); c16 <= 1'($urandom);
    a32 <= $urandom; b32 <= $urandom; c32 <= 1'($urandom);
    @(negedge clk);
  endtask

  task automatic checkWide();
    logic [16:0] e16;
    logic [32:0] e32;
    e16 = {1'b0, a16} + {1'b0, b16} + 17'(c16);
    e32 = {1'b0, a32} + {1'b0, b32} + 33'(c32);
    chk("R6 16b", 33'({co16, s16}), 33'(e16));
    chk("R6 32b", {co32, s32}, e32);
  endtask

  task automatic fullCheck8(input logic [7:0] a, input logic [7:0] b, input logic c);
    logic [8:0] e;
    logic [4:0] lo;
    logic [4:0] hi;
    drive8(a, b, c);
    e  = {1'b0, a} + {1'b0, b} + 9'(c);
    lo = {1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(c);
    hi = {1'b0, a[7:4]} + {1'b0, b[7:4]} + 5'(lo[4]);
    chk("R1", 33'({co8, s8}), 33'(e));
    chk("R2 low section", 33'(s8[3:0]), 33'(lo[3:0]));
    chk("R3 high section", 33'(s8[7:4]), 33'(hi[3:0]));
    checkWide();
  endtask

  initial begin
    logic [8:0] first;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state: all-zero inputs give zero result
    chk("R1 zero inputs", 33'({co8, s8}), 33'd0);

    // R5 full propagate, both carry values
    fullCheck8(8'hFF, 8'h00, 1'b1);
    chk("R5 cin1", 33'({co8, s8}), 33'h100);
    fullCheck8(8'hFF, 8'h00, 1'b0);
    chk("R5 cin0", 33'({co8, s8}), 33'h0FF);

    // R4 upper section generates regardless of carryIn
    fullCheck8(8'hF0, 8'h10, 1'b0);
    chk("R4 cin0", 33'(co8), 33'd1);
    fullCheck8(8'hF0, 8'h10, 1'b1);
    chk("R4 cin1", 33'(co8), 33'd1);

    // R3 lower generates, upper propagates
    fullCheck8(8'hF8, 8'h08, 1'b0);
    chk("R3 ripple", 33'({co8, s8}), 33'h100);
    // R2/R3 both selects move together
    fullCheck8(8'h0F, 8'h00, 1'b1);
    chk("R3 select flip", 33'(s8), 33'h10);

    // R7 history independence
    fullCheck8(8'h5A, 8'h3C, 1'b1);
    first = {co8, s8};
    fullCheck8(8'hFF, 8'hFF, 1'b1);
    fullCheck8(8'h5A, 8'h3C, 1'b1);
    chk("R7 repeat", 33'({co8, s8}), 33'(first));

    // R1 exhaustive sweep with R6 random wide vectors alongside
    for (int v = 0; v < 131072; v++) begin
      logic [8:0] e;
      drive8(v[7:0], v[15:8], v[16]);
      e = {1'b0, v[7:0]} + {1'b0, v[15:8]} + 9'(v[16]);
      chk("R1 sweep", 33'({co8, s8}), 33'(e));
      checkWide();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule